// File: doc/BRIEF.md
# Bus Cycle Error Monitor

The monitor watches every external bus cycle a master opens and decides how that cycle ends. A cycle ends normally when the addressed slave returns a transfer acknowledge. If no acknowledge comes within a programmable number of clocks, the monitor pulls the active-low transfer-error line itself. Any of several other error sources can also pull that line. The line is modelled as a wired-OR, so one source is enough to make it active. When a cycle ends with an error, the monitor sends a one-clock interrupt request to the master that owned the cycle. A sticky log bit records whether the most recent error came from the timer or from an outside source.

A master pulses `cycleStart` together with its own number and the timeout to use. The monitor latches both values for the length of the cycle. When the error line is active at a clock edge, that edge ends the cycle with an error, even if an acknowledge arrives in the same clock. The line is driven for one clock only. This releases it before the second rising edge after it was sampled, so the next cycle does not see a stale error.

Top module: `bus_err_monitor`

## Requirements
- R1: After reset, `xferErrN` is 1, and `cycleDone`, `cycleErr`, `errIrq`, `errLogged` and `errLoggedExt` are all 0.
- R2: The cycle opens at the edge that samples `cycleStart`, called edge 0. An acknowledge sampled at edge n, with 1 <= n <= T (T being the latched timeout), ends the cycle normally. `cycleDone`=1 and `cycleErr`=0 for the one clock after edge n, and `xferErrN` stays 1.
- R3: If T > 0 and no acknowledge is sampled at edges 1..T, `xferErrN` is 0 for the one clock after edge T. Edge T+1 then ends the cycle with `cycleDone`=1 and `cycleErr`=1.
- R4: An acknowledge sampled at the same edge as an active `xferErrN` does not make the end normal. The cycle still ends with `cycleErr`=1.
- R5: Any single bit of `extErrReq` that is high at an open-cycle edge without an acknowledge drives `xferErrN` to 0 for the next clock, and the cycle then ends with an error. If the acknowledge comes at that same edge, the request is ignored.
- R6: `xferErrN` is low for exactly one clock per failing cycle, even if an external request is held high for longer.
- R7: A latched timeout of 0 disables the timer. The cycle then waits without limit, and only an acknowledge or an external request ends it.
- R8: With an error end, `errIrq` is one-hot at bit `masterId` (as latched at the start) for the same clock as `cycleDone`. It is all zero otherwise.
- R9: An error end sets `errLogged`=1 and sets `errLoggedExt` to 1 for an external source or 0 for the timer. If both causes arise at the same edge, the external source is recorded. A pulse on `statusClr` clears both bits, unless an error end happens at that same edge.
- R10: While no cycle is open, `extErrReq` is ignored. A `cycleStart` that arrives during an open cycle is also ignored and does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycleStart | input | 1 | One-clock strobe opening a bus cycle |
| masterId | input | MID_W | Owner of the cycle, latched at the start |
| timeoutVal | input | CNT_W | Clocks to wait for acknowledge; 0 disables |
| xferAck | input | 1 | Transfer acknowledge from the slave |
| extErrReq | input | N_EXT | Error requests from other sources |
| statusClr | input | 1 | Clears the sticky error log |
| xferErrN | output | 1 | Transfer-error line, active low, wired-OR of all sources |
| cycleDone | output | 1 | One-clock pulse when a cycle ends |
| cycleErr | output | 1 | With cycleDone: the cycle ended with an error |
| errIrq | output | N_MASTER | One-hot error interrupt to the owning master |
| errLogged | output | 1 | Sticky: an error end has occurred |
| errLoggedExt | output | 1 | Sticky: the last error came from an external source |

## Verification
The bench targets the edges of the timeout window. An acknowledge at edge T must pass, and one at edge T+1 must lose. A counter that is off by one moves the error pulse or lets a late acknowledge win. A design that lets acknowledge beat an active error line reports a clean end when the end should be an error. A held external request must yield a single low clock. A level-driven output would hold the line low into the next cycle. The bench also checks that a timeout of zero waits without limit instead of firing at once or wrapping. It checks that a second start strobe during an open cycle leaves the timer running from the first one, that idle-time error requests leave the line high, and that the interrupt goes to the latched master and not to whichever master is on the inputs at the end.

// File: rtl/bcem_pkg.sv
package bcem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FLAG = 2'd2
  } mon_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch limit and owner, clear counter
    logic inc;     // advance the wait counter
    logic errEnd;  // cycle ends with an error this edge
    logic errExt;  // the error came from an external source
    logic clrLog;  // clear the sticky log
  } mon_strobe_t;

endpackage

// File: rtl/bcem_datapath.sv
module bcem_datapath
  import bcem_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int N_MASTER = 4,
  parameter int MID_W    = $clog2(N_MASTER)
) (
  input  logic                clk,
  input  logic                rstN,
  input  mon_strobe_t         stb,
  input  logic [CNT_W-1:0]    timeoutVal,
  input  logic [MID_W-1:0]    masterId,
  output logic                hit,
  output logic [N_MASTER-1:0] errIrq,
  output logic                errLogged,
  output logic                errLoggedExt
);

  logic [CNT_W-1:0]    waitCnt;
  logic [CNT_W-1:0]    limit;
  logic [MID_W-1:0]    owner;
  logic [N_MASTER-1:0] ownerHot;

  // the timer fires on the clock that would be the limit-th without acknowledge
  assign hit = (limit != '0) && (waitCnt == limit - 1'b1);

  for (genvar i = 0; i < N_MASTER; i++) begin : g_owner
    assign ownerHot[i] = (owner == MID_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      limit   <= '0;
      owner   <= '0;
    end else if (stb.load) begin
      waitCnt <= '0;
      limit   <= timeoutVal;
      owner   <= masterId;
    end else if (stb.inc && (limit != '0)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errIrq <= '0;
    end else begin
      errIrq <= stb.errEnd ? ownerHot : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLogged    <= 1'b0;
      errLoggedExt <= 1'b0;
    end else if (stb.errEnd) begin
      errLogged    <= 1'b1;
      errLoggedExt <= stb.errExt;
    end else if (stb.clrLog) begin
      errLogged    <= 1'b0;
      errLoggedExt <= 1'b0;
    end
  end

endmodule

// File: rtl/bcem_control.sv
module bcem_control
  import bcem_pkg::*;
#(
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic             xferAck,
  input  logic [N_EXT-1:0] extErrReq,
  input  logic             statusClr,
  input  logic             hit,
  output mon_strobe_t      stb,
  output logic             errPulse,
  output logic             cycleDone,
  output logic             cycleErr
);

  mon_state_t state;
  mon_state_t stateNext;
  logic       extAny;
  logic       raise;
  logic       pulseExt;

  assign extAny = |extErrReq;
  assign raise  = (state == ST_WAIT) && !xferAck && (extAny || hit);

  always_comb begin
    stateNext  = state;
    stb        = '0;
    stb.errExt = pulseExt;
    stb.clrLog = statusClr;
    unique case (state)
      ST_IDLE: begin
        if (cycleStart) begin
          stb.load  = 1'b1;
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (xferAck) begin
          stateNext = ST_IDLE;
        end else if (extAny || hit) begin
          stateNext = ST_FLAG;
        end else begin
          stb.inc = 1'b1;
        end
      end
      ST_FLAG: begin
        stb.errEnd = 1'b1;
        stateNext  = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      errPulse  <= 1'b0;
      pulseExt  <= 1'b0;
      cycleDone <= 1'b0;
      cycleErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      errPulse  <= raise;
      if (raise) pulseExt <= extAny;
      cycleDone <= ((state == ST_WAIT) && xferAck) || (state == ST_FLAG);
      cycleErr  <= (state == ST_FLAG);
    end
  end

endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
  import bcem_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int N_EXT    = 3,
  parameter int N_MASTER = 4,
  parameter int MID_W    = $clog2(N_MASTER)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycleStart,
  input  logic [MID_W-1:0]    masterId,
  input  logic [CNT_W-1:0]    timeoutVal,
  input  logic                xferAck,
  input  logic [N_EXT-1:0]    extErrReq,
  input  logic                statusClr,
  output logic                xferErrN,
  output logic                cycleDone,
  output logic                cycleErr,
  output logic [N_MASTER-1:0] errIrq,
  output logic                errLogged,
  output logic                errLoggedExt
);

  mon_strobe_t stb;
  logic        hit;
  logic        errPulse;

  bcem_control #(.N_EXT(N_EXT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .xferAck    (xferAck),
    .extErrReq  (extErrReq),
    .statusClr  (statusClr),
    .hit        (hit),
    .stb        (stb),
    .errPulse   (errPulse),
    .cycleDone  (cycleDone),
    .cycleErr   (cycleErr)
  );

  bcem_datapath #(.CNT_W(CNT_W), .N_MASTER(N_MASTER), .MID_W(MID_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .timeoutVal   (timeoutVal),
    .masterId     (masterId),
    .hit          (hit),
    .errIrq       (errIrq),
    .errLogged    (errLogged),
    .errLoggedExt (errLoggedExt)
  );

  // open-drain style: low while any source holds the line
  assign xferErrN = ~errPulse;

endmodule

// File: rtl/bus_err_monitor_chk.sv
module bus_err_monitor_chk #(
  parameter int CNT_W    = 8,
  parameter int N_EXT    = 3,
  parameter int N_MASTER = 4,
  parameter int MID_W    = $clog2(N_MASTER)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cycleStart,
  input logic [MID_W-1:0]    masterId,
  input logic [CNT_W-1:0]    timeoutVal,
  input logic                xferAck,
  input logic [N_EXT-1:0]    extErrReq,
  input logic                statusClr,
  input logic                xferErrN,
  input logic                cycleDone,
  input logic                cycleErr,
  input logic [N_MASTER-1:0] errIrq,
  input logic                errLogged,
  input logic                errLoggedExt
);

  // R6
  err_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferErrN |=> xferErrN);

  // R4
  err_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferErrN |=> (cycleDone && cycleErr));

  // R2
  err_flag_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleErr |-> cycleDone);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R8
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycleErr |-> ($countones(errIrq) == 1));

  // R8
  irq_only_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq != '0) |-> cycleErr);

  // R9
  log_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errLogged) |-> cycleErr);

endmodule

bind bus_err_monitor bus_err_monitor_chk #(
  .CNT_W(CNT_W), .N_EXT(N_EXT), .N_MASTER(N_MASTER), .MID_W(MID_W)
) u_chk (.*);

// File: tb/bus_err_monitor_tb.sv
module bus_err_monitor_tb;

  localparam int CNT_W    = 8;
  localparam int N_EXT    = 3;
  localparam int N_MASTER = 4;
  localparam int MID_W    = 2;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                cycleStart = 1'b0;
  logic [MID_W-1:0]    masterId = '0;
  logic [CNT_W-1:0]    timeoutVal = '0;
  logic                xferAck = 1'b0;
  logic [N_EXT-1:0]    extErrReq = '0;
  logic                statusClr = 1'b0;
  logic                xferErrN;
  logic                cycleDone;
  logic                cycleErr;
  logic [N_MASTER-1:0] errIrq;
  logic                errLogged;
  logic                errLoggedExt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_err_monitor #(.CNT_W(CNT_W), .N_EXT(N_EXT), .N_MASTER(N_MASTER), .MID_W(MID_W)) u_dut (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .masterId(masterId),
    .timeoutVal(timeoutVal), .xferAck(xferAck), .extErrReq(extErrReq),
    .statusClr(statusClr), .xferErrN(xferErrN), .cycleDone(cycleDone),
    .cycleErr(cycleErr), .errIrq(errIrq), .errLogged(errLogged),
    .errLoggedExt(errLoggedExt)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  // timeout, ack edge, ext edge (0 = none), master, expected done edge,
  // error end, edge after which the line is low (0 = never), external source
  typedef struct packed {
    int t; int ack; int ext; int m; int done; int err; int pulse; int xe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4, 2, 0, 0, 2, 0, 0, 0},  // R2 early ack
    '{4, 4, 0, 1, 4, 0, 0, 0},  // R2 ack on the last allowed edge
    '{4, 5, 0, 2, 5, 1, 4, 0},  // R3 one edge late, R4 ack loses
    '{4, 0, 0, 3, 5, 1, 4, 0},  // R3 no ack at all
    '{1, 0, 0, 3, 2, 1, 1, 0},  // R3 shortest window
    '{1, 1, 0, 0, 1, 0, 0, 0},  // R2 shortest window, ack in time
    '{6, 0, 2, 2, 3, 1, 2, 1},  // R5 external source
    '{6, 3, 3, 1, 3, 0, 0, 0},  // R5 ack at same edge as request wins
    '{3, 0, 3, 0, 4, 1, 3, 1},  // R9 timer and request together: external logged
    '{0, 9, 0, 1, 9, 0, 0, 0},  // R7 timer disabled, late ack ends normally
    '{0, 0, 5, 2, 6, 1, 5, 1},  // R7 timer disabled, request still works
    '{2, 3, 0, 1, 3, 1, 2, 0}   // R4 ack coincides with sampled error
  };

  int pulseAt, lowCnt, doneAt, gotErr, gotIrq, gotExt, gotLog;

  // open a cycle and step it; ext request on bit (m % N_EXT) for one edge
  task automatic runCycle(input int t, input int ackAt, input int extAt, input int m);
    @(negedge clk);
    timeoutVal = CNT_W'(t);
    masterId   = MID_W'(m);
    cycleStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cycleStart = 1'b0;
    masterId   = MID_W'(m + 1);  // owner must come from the latched value
    pulseAt = 0; lowCnt = 0; doneAt = 0; gotErr = 0; gotIrq = 0; gotExt = 0; gotLog = 0;
    for (int k = 1; k <= 60 && doneAt == 0; k++) begin
      xferAck   = (k == ackAt);
      extErrReq = (k == extAt) ? N_EXT'(1 << (m % N_EXT)) : '0;
      @(posedge clk);
      @(negedge clk);
      xferAck   = 1'b0;
      extErrReq = '0;
      if (!xferErrN) begin
        lowCnt++;
        if (pulseAt == 0) pulseAt = k;
      end
      if (cycleDone) begin
        doneAt = k;
        gotErr = int'(cycleErr);
        gotIrq = int'(errIrq);
        gotExt = int'(errLoggedExt);
        gotLog = int'(errLogged);
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "xferErrN", int'(xferErrN), 1);
    check("R1", "cycleDone", int'(cycleDone), 0);
    check("R1", "cycleErr", int'(cycleErr), 0);
    check("R1", "errIrq", int'(errIrq), 0);
    check("R1", "errLogged", int'(errLogged), 0);
    check("R1", "errLoggedExt", int'(errLoggedExt), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      runCycle(VECS[v].t, VECS[v].ack, VECS[v].ext, VECS[v].m);
      check("R2", $sformatf("vec %0d done edge", v), doneAt, VECS[v].done);
      check("R4", $sformatf("vec %0d error end", v), gotErr, VECS[v].err);
      check("R3", $sformatf("vec %0d low edge", v), pulseAt, VECS[v].pulse);
      check("R6", $sformatf("vec %0d low clocks", v), lowCnt, VECS[v].err);
      check("R8", $sformatf("vec %0d irq", v), gotIrq, VECS[v].err != 0 ? (1 << VECS[v].m) : 0);
      if (VECS[v].err != 0) begin
        check("R9", $sformatf("vec %0d logged", v), gotLog, 1);
        check("R5", $sformatf("vec %0d source ext", v), gotExt, VECS[v].xe);
      end
    end

    // R9 clear of the sticky log
    @(negedge clk);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    check("R9", "logged after clear", int'(errLogged), 0);
    check("R9", "ext after clear", int'(errLoggedExt), 0);

    // R10 requests while idle are ignored
    lowCnt = 0;
    extErrReq = '1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!xferErrN) lowCnt++;
    end
    extErrReq = '0;
    check("R10", "idle request low clocks", lowCnt, 0);
    check("R10", "idle request logged", int'(errLogged), 0);

    // R10 second start inside an open cycle does not restart the timer
    @(negedge clk);
    timeoutVal = 8'd3; masterId = 2'd1; cycleStart = 1'b1;
    @(negedge clk);
    pulseAt = 0;
    for (int k = 1; k <= 6; k++) begin
      cycleStart = (k == 1);
      @(negedge clk);
      if (!xferErrN && pulseAt == 0) pulseAt = k;
    end
    cycleStart = 1'b0;
    check("R10", "restart ignored, low edge", pulseAt, 3);

    // R6 held request gives one low clock; R5 ext source with timer off
    @(negedge clk);
    timeoutVal = 8'd0; masterId = 2'd2; cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    extErrReq = 3'b100;
    lowCnt = 0; doneAt = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (!xferErrN) lowCnt++;
      if (cycleDone) doneAt = k;
    end
    extErrReq = '0;
    check("R6", "held request low clocks", lowCnt, 1);
    check("R5", "held request done edge", doneAt, 2);
    check("R5", "held request source ext", int'(errLoggedExt), 1);

    // R7 timer off waits without limit
    runCycle(0, 300, 0, 3);
    check("R7", "long wait done edge", doneAt, 0);
    check("R7", "long wait low clocks", lowCnt, 0);
    lowCnt = 0; doneAt = 0;
    for (int k = 61; k <= 300 && doneAt == 0; k++) begin
      xferAck = (k == 300);
      @(negedge clk);
      xferAck = 1'b0;
      if (!xferErrN) lowCnt++;
      if (cycleDone) begin doneAt = k; gotErr = int'(cycleErr); end
    end
    check("R7", "long wait ack edge", doneAt, 300);
    check("R7", "long wait normal end", gotErr, 0);
    check("R7", "long wait no error", lowCnt, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule